// File: doc/BRIEF.md
# CPU Clock Source Controller

This block holds an 8-bit control register written and read over a simple register port, and turns its fields into a single-cycle clock enable for the CPU. The CPU runs either from the main oscillator tick, thinned to full rate, one half, one eighth or one sixteenth, or from a separate subsystem clock tick. The same register carries a request to halt the main oscillator and a flag that allows an external interrupt to wake the part from Stop mode.

Rate division comes from a free-running 4-bit counter that advances on main oscillator ticks. The enable is gated from that counter, and no new clock is generated. A new source or rate is adopted only when the current period ends. This keeps every enable pulse whole. A halt request takes effect only while the subsystem clock is the active source, so the CPU is never left without a clock.

Top module: `cpu_clk_ctrl`

## Requirements
- R1: A write stores all 8 data bits, and `reg_rdata` returns the last written byte unchanged, including codes that have no effect.
- R2: After reset the register reads 0x00, `wake_en` is 1, `main_osc_run` is 1 and the CPU runs at one sixteenth of the main tick rate.
- R3: `wake_en` is the inverse of bit 7: a 0 enables interrupt wake-up from Stop and a 1 disables it.
- R4: Bits 4:3 select the main rate. 00 gives one `cpu_ce` pulse per 16 main ticks, 01 gives one per 8, 10 gives one per 2 and 11 gives one on every tick. Each pulse lasts one cycle and coincides with a main tick.
- R5: When bits 2:0 equal 101, `cpu_ce` follows `sub_tick` whatever bits 4:3 hold, and main ticks produce no enable.
- R6: Any other value of bits 2:0, such as 100 or 111, selects the main oscillator.
- R7: With the subsystem clock active, bits 6:5 = 10 drive `main_osc_run` low. The values 00, 01 and 11 keep it high.
- R8: While the main oscillator is the active CPU source, `main_osc_run` stays high even when bits 6:5 hold 10.
- R9: A new source or rate takes effect only at a period boundary. For the main source this is the main tick on which the counter reaches 15. For the subsystem source it is the next subsystem tick.
- R10: On a return from the subsystem clock to the main oscillator, division restarts with a fresh count, so the first period is a full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| main_tick | input | 1 | One-cycle tick from the main oscillator |
| sub_tick | input | 1 | One-cycle tick from the subsystem clock |
| cpu_ce | output | 1 | One-cycle CPU clock enable |
| main_osc_run | output | 1 | High while the main oscillator must keep running |
| wake_en | output | 1 | High when an external interrupt may wake the part from Stop |

## Verification
The hardest case to reach is a write that changes the source while the main oscillator is halted. The switch back to the main clock has to wait for a subsystem tick, and until then the oscillator must stay off. The stimulus first moves to the subsystem clock and sets the halt code. It then writes a main-clock selection and checks that `main_osc_run` stays low. Next it issues a single subsystem tick and checks that the oscillator restarts and that the next 16 main ticks form a full, freshly counted period. Every rate change is written at a counter boundary, so the bench can predict which old-rate pulses still occur before the new rate applies.

// File: rtl/cpu_clk_ctrl.sv
module cpu_clk_ctrl #(
  parameter int          CNT_W     = 4,
  parameter logic [2:0]  SUB_CODE  = 3'b101,
  parameter logic [1:0]  STOP_CODE = 2'b10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       main_tick,
  input  logic       sub_tick,
  output logic       cpu_ce,
  output logic       main_osc_run,
  output logic       wake_en
);

  localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};

  logic [7:0]       ctl;
  logic             act_sub;
  logic [1:0]       act_div;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] mask;
  logic             wrap;
  logic             ce_main;

  always_comb begin
    case (act_div)
      2'b00:   mask = ALL1;
      2'b01:   mask = ALL1 >> 1;
      2'b10:   mask = {{(CNT_W-1){1'b0}}, 1'b1};
      default: mask = '0;
    endcase
  end

  assign ce_main      = main_tick && ((cnt & mask) == mask);
  assign wrap         = act_sub ? sub_tick : (main_tick && (cnt == ALL1));
  assign cpu_ce       = act_sub ? sub_tick : ce_main;
  assign main_osc_run = !(act_sub && (ctl[6:5] == STOP_CODE));
  assign wake_en      = ~ctl[7];
  assign reg_rdata    = ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl     <= '0;
      act_sub <= 1'b0;
      act_div <= 2'b00;
      cnt     <= '0;
    end else begin
      if (reg_we) ctl <= reg_wdata;
      if (wrap) begin
        act_sub <= (ctl[2:0] == SUB_CODE);
        act_div <= ctl[4:3];
      end
      if (act_sub)        cnt <= '0;
      else if (main_tick) cnt <= cnt + 1'b1;
    end
  end

  a_r1_readback: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(reg_we)) |-> (reg_rdata == $past(reg_wdata)));

  a_r4_ce_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ce |-> (main_tick || sub_tick));

  a_r5_sub_blocks_main: assert property (@(posedge clk) disable iff (!rst_n)
    (act_sub && !sub_tick) |-> !cpu_ce);

  a_r8_main_keeps_osc: assert property (@(posedge clk) disable iff (!rst_n)
    !act_sub |-> main_osc_run);

  a_r9_hold_until_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> ($stable(act_sub) && $stable(act_div)));

  a_r10_fresh_count: assert property (@(posedge clk) disable iff (!rst_n)
    (act_sub && wrap && (ctl[2:0] != SUB_CODE)) |=> (cnt == '0));

endmodule

// File: tb/tb_cpu_clk_ctrl.sv
module tb_cpu_clk_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       main_tick = 1'b0;
  logic       sub_tick = 1'b0;
  logic       cpu_ce, main_osc_run, wake_en;

  int ntests = 0;
  int nfail  = 0;
  logic  q_exp[$];
  string q_tag[$];

  always #5 clk = ~clk;

  cpu_clk_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .main_tick(main_tick), .sub_tick(sub_tick),
    .cpu_ce(cpu_ce), .main_osc_run(main_osc_run), .wake_en(wake_en)
  );

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #2;
      if (q_exp.size() > 0) begin
        logic  e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        check8(t, {7'd0, cpu_ce}, {7'd0, e});
      end
    end
  end

  task automatic cyc(input logic mt, input logic st, input logic exp, input string tag);
    @(negedge clk);
    reg_we = 1'b0; main_tick = mt; sub_tick = st;
    q_exp.push_back(exp);
    q_tag.push_back(tag);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_wdata = d; main_tick = 1'b0; sub_tick = 1'b0;
    q_exp.push_back(1'b0);
    q_tag.push_back("R4 ce idle during write");
  endtask

  task automatic settle;
    @(negedge clk);
    reg_we = 1'b0; main_tick = 1'b0; sub_tick = 1'b0;
    #2;
  endtask

  task automatic run_main(input int n, input int p, input string tag);
    for (int k = 0; k < n; k++) cyc(1'b1, 1'b0, ((k + 1) % p) == 0, tag);
  endtask

  initial begin : watchdog
    #1000000;
    nfail++;
    $display("FAIL R9 watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin : stim
    #23 rst_n = 1'b1;
    settle();
    check8("R2 reset rdata", reg_rdata, 8'h00);
    check8("R2 reset wake_en", {7'd0, wake_en}, 8'd1);
    check8("R2 reset osc run", {7'd0, main_osc_run}, 8'd1);
    run_main(32, 16, "R2 R4 div16");

    wr(8'h08);
    run_main(16, 16, "R9 old div16 until wrap");
    run_main(16, 8, "R4 div8");
    wr(8'h10);
    run_main(16, 8, "R9 old div8 until wrap");
    run_main(16, 2, "R4 div2");
    wr(8'h18);
    run_main(16, 2, "R9 old div2 until wrap");
    run_main(16, 1, "R4 div1");

    wr(8'h40);
    settle();
    check8("R8 stop ignored on main", {7'd0, main_osc_run}, 8'd1);
    check8("R1 readback 40", reg_rdata, 8'h40);
    run_main(16, 1, "R9 div1 until wrap");
    run_main(16, 16, "R8 main still clocks div16");

    wr(8'h1D);
    run_main(16, 16, "R9 main until wrap before sub");
    for (int k = 0; k < 8; k++) cyc(1'b0, k[0], k[0], "R5 ce follows sub");
    for (int k = 0; k < 6; k++) cyc(1'b1, 1'b0, 1'b0, "R5 main ticks ignored");

    wr(8'h5D);
    settle();
    check8("R7 stop drops osc", {7'd0, main_osc_run}, 8'd0);
    check8("R1 readback 5D", reg_rdata, 8'h5D);
    wr(8'h3D);
    settle();
    check8("R7 code 01 keeps osc", {7'd0, main_osc_run}, 8'd1);
    check8("R1 readback 3D", reg_rdata, 8'h3D);
    wr(8'h7D);
    settle();
    check8("R7 code 11 keeps osc", {7'd0, main_osc_run}, 8'd1);
    wr(8'h4D);
    settle();
    check8("R7 stop again", {7'd0, main_osc_run}, 8'd0);

    wr(8'h5C);
    settle();
    check8("R9 sub held until sub tick", {7'd0, main_osc_run}, 8'd0);
    cyc(1'b1, 1'b0, 1'b0, "R9 main tick while sub pending");
    cyc(1'b0, 1'b1, 1'b1, "R9 last sub tick");
    settle();
    check8("R6 R8 back on main osc runs", {7'd0, main_osc_run}, 8'd1);
    run_main(16, 1, "R10 R6 fresh count div1");

    wr(8'h8F);
    settle();
    check8("R3 bit7 set wake off", {7'd0, wake_en}, 8'd0);
    check8("R1 readback 8F", reg_rdata, 8'h8F);
    run_main(16, 1, "R9 div1 until wrap");
    run_main(16, 8, "R6 code 111 main div8");
    wr(8'h0F);
    settle();
    check8("R3 bit7 clear wake on", {7'd0, wake_en}, 8'd1);

    settle();
    settle();
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule